// File: doc/BRIEF.md
# Bus wake-up pattern detector

This block watches the bus while the transceiver sits in its low-power state. It takes a sampled bus-dominant indication from the low-power receiver and looks for a three-part wake-up sequence. The sequence is a dominant stretch, then a recessive stretch, then a second dominant stretch. Every stretch must be held for a minimum number of clock cycles before it counts, so short pulses on the bus are filtered out. The whole sequence must finish inside a timeout window measured from its first dominant sample. If it does not, the detector drops back to idle and waits for a fresh start.

Once the sequence is recognized, the block raises a sticky wake flag. The mode controller uses this flag to let the receive output follow the bus. The flag stays high until standby is left or reset is applied. While standby is inactive, the bus is ignored. The bus input is resynchronized with two flops before the detector uses it. Below, a "sample" means one clock cycle of the bus-dominant input, and sample 1 is the first dominant sample taken from idle. `FILT_CYC` is the minimum phase length and must be at least 2. `TO_CYC` is the timeout length.

Top module: `wake_pattern_det`

## Requirements
- R1: After `rst_ni` is released, `wake_o` is 0.
- R2: A dominant phase, then a recessive phase, then a dominant phase, each at least `FILT_CYC` samples long and completed within the timeout, sets `wake_o` to 1.
- R3: A first dominant phase shorter than `FILT_CYC` samples is discarded and the detector goes back to idle. A later dominant-recessive pair alone then produces no wake.
- R4: A recessive gap shorter than `FILT_CYC` samples after a qualified first phase is absorbed into that first phase. The detector keeps waiting for a qualified recessive phase, so the sequence can still complete.
- R5: A third dominant phase shorter than `FILT_CYC` samples does not wake the block. The detector returns to waiting for the third phase to begin again.
- R6: The sequence is accepted when the `FILT_CYC`-th sample of the third phase is sample number `TO_CYC` or earlier. If that sample would come later, the detector returns to idle at sample `TO_CYC`.
- R7: While `stby_i` stays high, `wake_o` stays at 1 once it is set, whatever the bus does.
- R8: When `stby_i` is low, `wake_o` is cleared on the next clock edge and the bus input has no effect.
- R9: `wake_o` rises on the third rising clock edge after the qualifying third-phase sample is presented: two edges of synchronization and one edge for the state update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stby_i | input | 1 | High while the device is in standby; enables detection |
| bus_dom_i | input | 1 | Low-power receiver output, 1 = bus dominant (asynchronous) |
| wake_o | output | 1 | Sticky wake-up recognized flag |

## Verification
The bench places phase lengths just on either side of the filter length. A detector with an off-by-one filter would wake on a short third phase, or would count a short first pulse as phase one. Glitches of one and two samples are inserted inside the first and third phases. A design that restarts from idle on such a glitch would miss a wake that is still valid. The timeout is tested at exactly `TO_CYC` samples and at one sample more, which catches a window that is one cycle too long or too short. The standby tests check that the flag clears immediately and that a complete pattern presented with standby low leaves it clear.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DOM1 = 3'd1,
    ST_REC  = 3'd2,
    ST_DOM2 = 3'd3,
    ST_DONE = 3'd4
  } wake_st_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int TO_CYC = 1000,
  localparam int TW = $clog2(TO_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,    // sequence active in the next cycle
  input  logic          busy_i,   // sequence active in this cycle
  output logic          expire_o,
  output logic [TW-1:0] cnt_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  // cnt_q holds the number of samples already consumed, so the sample
  // now being processed is number cnt_q + 1
  assign expire_o = busy_i && (cnt_q == TW'(TO_CYC - 1));
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
  import wake_pkg::*;
#(
  parameter int FILT_CYC = 16,
  localparam int FW = $clog2(FILT_CYC + 1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     dom_i,
  input  logic     expire_i,
  output wake_st_e state_o,
  output logic     run_o,
  output logic     busy_o
);
  localparam logic [FW-1:0] FMAX = FW'(FILT_CYC);

  wake_st_e      state_q, state_d;
  logic [FW-1:0] flt_q, flt_d;
  logic [FW-1:0] flt_inc;

  assign flt_inc = (flt_q == FMAX) ? FMAX : flt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    flt_d   = flt_q;
    unique case (state_q)
      ST_IDLE: if (dom_i) begin state_d = ST_DOM1; flt_d = FW'(1); end
      ST_DOM1: begin
        if (dom_i)               flt_d = flt_inc;
        else if (flt_q == FMAX) begin state_d = ST_REC;  flt_d = FW'(1); end
        else                    begin state_d = ST_IDLE; flt_d = '0;     end
      end
      ST_REC: begin
        if (!dom_i)              flt_d = flt_inc;
        else if (flt_q == FMAX) begin state_d = ST_DOM2; flt_d = FW'(1); end
        else                    begin state_d = ST_DOM1; flt_d = FMAX;   end // gap absorbed
      end
      ST_DOM2: begin
        if (!dom_i)                    begin state_d = ST_REC; flt_d = FMAX; end
        else if (flt_q == FMAX - 1'b1) begin state_d = ST_DONE; flt_d = '0; end
        else                           flt_d = flt_inc;
      end
      ST_DONE: state_d = ST_DONE;
      default: begin state_d = ST_IDLE; flt_d = '0; end
    endcase
    if (expire_i && state_d != ST_DONE) begin
      state_d = ST_IDLE;
      flt_d   = '0;
    end
    if (!en_i) begin
      state_d = ST_IDLE;
      flt_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      flt_q   <= '0;
    end else begin
      state_q <= state_d;
      flt_q   <= flt_d;
    end
  end

  assign state_o = state_q;
  assign busy_o  = state_q inside {ST_DOM1, ST_REC, ST_DOM2};
  assign run_o   = state_d inside {ST_DOM1, ST_REC, ST_DOM2};
endmodule

// File: rtl/wake_pattern_det.sv
module wake_pattern_det
  import wake_pkg::*;
#(
  parameter int FILT_CYC = 16,
  parameter int TO_CYC   = 1000,
  localparam int TW = $clog2(TO_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_i,
  input  logic bus_dom_i,
  output logic wake_o
);
  logic          dom_s;
  logic          expire, run, busy;
  logic [TW-1:0] tcnt;
  wake_st_e      state_q;

  wake_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_dom_i),
    .q_o   (dom_s)
  );

  wake_timer #(.TO_CYC(TO_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .busy_i  (busy),
    .expire_o(expire),
    .cnt_o   (tcnt)
  );

  wake_fsm #(.FILT_CYC(FILT_CYC)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (stby_i),
    .dom_i   (dom_s),
    .expire_i(expire),
    .state_o (state_q),
    .run_o   (run),
    .busy_o  (busy)
  );

  assign wake_o = (state_q == ST_DONE);
endmodule

// File: rtl/wake_pattern_chk.sv
module wake_pattern_chk
  import wake_pkg::*;
#(
  parameter int TO_CYC = 1000,
  localparam int TW = $clog2(TO_CYC + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stby_i,
  input logic          wake_o,
  input wake_st_e      state_q,
  input logic [TW-1:0] tcnt
);
  p_stby_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_i |=> !wake_o);

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && stby_i) |=> wake_o);

  p_rise_from_third_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> ($past(state_q) == ST_DOM2));

  p_window_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tcnt < TW'(TO_CYC));

  p_idle_after_stby_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_i |=> (state_q == ST_IDLE));

  always_comb begin
    if (rst_ni) p_state_legal_r1: assert (state_q inside {ST_IDLE, ST_DOM1, ST_REC, ST_DOM2, ST_DONE});
  end
endmodule

bind wake_pattern_det wake_pattern_chk #(.TO_CYC(TO_CYC)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .stby_i (stby_i),
  .wake_o (wake_o),
  .state_q(state_q),
  .tcnt   (tcnt)
);

// File: tb/wake_pattern_det_test.sv
module wake_pattern_det_test;
  localparam int F  = 4;
  localparam int TO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby = 1'b0;
  logic bus = 1'b0;
  logic wake;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  wake_pattern_det #(.FILT_CYC(F), .TO_CYC(TO)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .stby_i   (stby),
    .bus_dom_i(bus),
    .wake_o   (wake)
  );

  task automatic chk(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: wake_o=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic drive(input logic lvl, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus = lvl;
    end
  endtask

  // leave standby, idle the bus, re-enter standby
  task automatic fresh();
    @(negedge clk);
    stby = 1'b0;
    bus  = 1'b0;
    drive(1'b0, 4);
    @(negedge clk);
    stby = 1'b1;
    drive(1'b0, 4);
  endtask

  task automatic pattern(input int a, input int b, input int c, input logic exp, input string req);
    fresh();
    drive(1'b1, a);
    drive(1'b0, b);
    drive(1'b1, c);
    drive(1'b0, 6);
    chk(wake, exp, req);
  endtask

  task automatic t_reset();
    chk(wake, 1'b0, "R1");
  endtask

  task automatic t_basic();
    pattern(F, F, F, 1'b1, "R2 minimum phases");
    pattern(7, 9, 5, 1'b1, "R2 longer phases");
  endtask

  task automatic t_short_first();
    pattern(F - 1, 6, 6, 1'b0, "R3 short first phase");
    pattern(F, F - 1, F, 1'b0, "R4 gap only, no qualified recessive");
  endtask

  task automatic t_gap_first();
    fresh();
    drive(1'b1, 6); drive(1'b0, 2); drive(1'b1, 3);
    drive(1'b0, 5); drive(1'b1, 5); drive(1'b0, 6);
    chk(wake, 1'b1, "R4 short gap absorbed");
  endtask

  task automatic t_short_third();
    pattern(5, 5, F - 1, 1'b0, "R5 short third phase");
    fresh();
    drive(1'b1, 5); drive(1'b0, 5); drive(1'b1, 2);
    drive(1'b0, 1); drive(1'b1, 4); drive(1'b0, 6);
    chk(wake, 1'b1, "R5 third phase restarted");
  endtask

  task automatic t_timeout();
    pattern(18, 18, F, 1'b1, "R6 completes at window end");
    pattern(18, 19, F, 1'b0, "R6 one sample late");
    pattern(20, 20, 6, 1'b0, "R6 long pattern");
  endtask

  task automatic t_sticky();
    pattern(5, 5, 5, 1'b1, "R7 setup");
    for (int i = 0; i < 5; i++) begin
      drive(1'b1, 3);
      drive(1'b0, 2);
      chk(wake, 1'b1, "R7 sticky under bus activity");
    end
  endtask

  task automatic t_stby();
    pattern(5, 5, 5, 1'b1, "R8 setup");
    @(negedge clk);
    stby = 1'b0;
    @(negedge clk);
    chk(wake, 1'b0, "R8 cleared one edge after standby exit");
    drive(1'b1, 6); drive(1'b0, 6); drive(1'b1, 6); drive(1'b0, 4);
    chk(wake, 1'b0, "R8 pattern ignored outside standby");
    @(negedge clk);
    stby = 1'b1;
    drive(1'b0, 6);
    chk(wake, 1'b0, "R8 no wake on re-entry");
  endtask

  task automatic t_latency();
    fresh();
    drive(1'b1, 5); drive(1'b0, 5); drive(1'b1, F);
    @(negedge clk); bus = 1'b0;
    chk(wake, 1'b0, "R9 not after first edge");
    @(negedge clk);
    chk(wake, 1'b0, "R9 not after second edge");
    @(negedge clk);
    chk(wake, 1'b1, "R9 high after third edge");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run expired, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_short_first();
    t_gap_first();
    t_short_third();
    t_timeout();
    t_sticky();
    t_stby();
    t_latency();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule